// File: doc/BRIEF.md
# MDIO Management Master Controller

This block is the station-management master of an Ethernet MAC. Software uses it to read and write the 16-bit registers of an external PHY over the two-wire management bus: a clock line (MDC) that only this block drives, and a shared bidirectional data line (MDIO). The block generates MDC by dividing the system clock, shifts out one complete clause-22 management frame per request and, on a read, collects the PHY's answer.

Software sees two registers. The command word holds a busy/start flag, the direction, a clock-range code, the PHY register number and the PHY address. The data word holds the 16-bit value. For a write, software loads the data word first and then writes the command word with the busy flag set. For a read, software writes the command word and polls until busy drops; the returned value is then in the data word. Both registers are frozen while a transaction runs.

The MDIO pad is modelled as three signals: an output value, an output enable and the sampled input. The pull-up that holds an undriven line high is outside the block.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, `cmd_rdata` and `data_rdata` read 0, `mdc` is low, `mdio_oe` is low and `mdio_o` is high.
- R2: The clock-range field is command bits [4:2]. It sets the MDC period in system clocks as follows: code 2 gives 16, code 3 gives 26, code 0 gives 42, code 1 gives 62, and codes 4 to 7 give 62. MDC is high for half of each period. A transaction takes exactly 64 MDC periods, counted from the clock edge that accepts the command to the edge where busy clears.
- R3: Command bit 0 is busy. Writing the command word with bit 0 set while idle starts a transaction. Busy clears in the same cycle as the 64th MDC falling edge. MDC stays low while busy is clear.
- R4: A write frame (command bit 1 = 1) puts these 64 bits on MDIO with the enable held high throughout: 32 ones, then 01, then 01, then the PHY address (bits [15:11]), then the register number (bits [10:6]), then 10, then the 16 data bits. Every field is sent MSB first.
- R5: A read frame (bit 1 = 0) sends the same first 46 bits, except that the opcode is 10. The enable is then low for the remaining 18 bit times. MDIO is sampled at the 16 MDC rising edges of the data phase, MSB first, and the result is placed in `data_rdata` when busy clears.
- R6: If no PHY answers a read, the line stays high and `data_rdata` becomes 0xFFFF.
- R7: While busy is set, writes to the command word and to the data word are ignored. This includes a command write in the same cycle that busy clears. The ignored write changes neither the frame in progress, nor its length, nor the fields read back afterwards.
- R8: A command write with bit 0 clear while idle updates the fields that read back, starts nothing and leaves MDC low. Command bit 5 and bits [31:16] always read 0.
- R9: `mdio_o` and `mdio_oe` change only in a cycle where MDC falls, or in the cycle that starts a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word write value |
| data_wr | input | 1 | Write strobe for the data word |
| data_wdata | input | 16 | Data word write value |
| cmd_rdata | output | 32 | Command word read value |
| data_rdata | output | 16 | Data word read value |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO sampled input |

## Verification
The end of a transaction and a new software command can fall in the same cycle. In that cycle, the engine's last MDC falling edge clears busy while a command write arrives. The bench counts system clocks from the start and places a command write with a different address, clock range and start flag exactly on the completion edge. It then checks that busy is clear, that no second transaction begins, and that the fields read back are those of the finished command. A write to the data word in the middle of a transaction is checked the same way: the bench decodes the frame seen on MDIO and compares it with the original value.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;

  localparam int BUSY_BIT = 0;
  localparam int WR_BIT   = 1;
  localparam int CR_LSB   = 2;
  localparam int REG_LSB  = 6;
  localparam int PHY_LSB  = 11;
  localparam int MAX_RATIO = 62;

  // MDC period in system clocks for a clock-range code
  function automatic int unsigned mdc_ratio(input logic [2:0] code);
    case (code)
      3'd0:    return 42;
      3'd1:    return 62;
      3'd2:    return 16;
      3'd3:    return 26;
      default: return 62;
    endcase
  endfunction

  // Value of frame bit idx (0 = first on the wire)
  function automatic logic frame_bit(input int unsigned idx, input int unsigned pre,
                                     input logic wr, input logic [4:0] phy,
                                     input logic [4:0] regad, input logic [15:0] dat);
    logic [31:0] hdr;
    hdr = {2'b01, !wr, wr, phy, regad, 2'b10, dat};
    if (idx < pre) return 1'b1;
    return hdr[5'(31 - (idx - pre))];
  endfunction

  // Master drives the line for this bit
  function automatic logic frame_oe(input int unsigned idx, input int unsigned pre,
                                    input logic wr);
    return wr || (idx < pre + 14);
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] half_m1,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [CNT_W-1:0] cnt;
  logic             tick;

  assign tick     = run && (cnt == half_m1);
  assign rise_evt = tick && !mdc;
  assign fall_evt = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_shifter.sv
`timescale 1ns/1ps
module mdio_frame_shifter
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rise_evt,
  input  logic        fall_evt,
  input  logic        wr,
  input  logic [4:0]  phy,
  input  logic [4:0]  regad,
  input  logic [15:0] wdata,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic [15:0] rdata,
  output logic [$clog2(PRE_LEN+32)-1:0] bit_idx
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] DATA_FIRST = IDX_W'(PRE_LEN + 16);

  logic        last;
  int unsigned nxt;

  assign last = (bit_idx == LAST_IDX);
  assign done = fall_evt && last;
  assign nxt  = 32'(bit_idx) + 32'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rdata   <= '0;
    end else begin
      if (start) begin
        bit_idx <= '0;
        mdio_o  <= frame_bit(0, PRE_LEN, wr, phy, regad, wdata);
        mdio_oe <= frame_oe(0, PRE_LEN, wr);
      end else if (fall_evt) begin
        if (last) begin
          bit_idx <= '0;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
        end else begin
          bit_idx <= bit_idx + IDX_W'(1);
          mdio_o  <= frame_bit(nxt, PRE_LEN, wr, phy, regad, wdata);
          mdio_oe <= frame_oe(nxt, PRE_LEN, wr);
        end
      end
      if (rise_evt && (bit_idx >= DATA_FIRST))
        rdata <= {rdata[14:0], mdio_i};
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
`timescale 1ns/1ps
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  input  logic        data_wr,
  input  logic [15:0] data_wdata,
  output logic [31:0] cmd_rdata,
  output logic [15:0] data_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int CNT_W = $clog2(MAX_RATIO / 2);
  localparam int IDX_W = $clog2(PRE_LEN + 32);

  logic             busy, wr_q;
  logic [2:0]       cr_q;
  logic [4:0]       reg_q, phy_q;
  logic [15:0]      data_q, rx_word;
  logic [CNT_W-1:0] half_m1;
  logic             start_evt, done_evt, rise_evt, fall_evt;
  logic [IDX_W-1:0] bit_idx;
  logic             unused_bits;

  assign unused_bits = ^{cmd_wdata[31:16], cmd_wdata[5]};
  assign start_evt   = cmd_wr && !busy && cmd_wdata[BUSY_BIT];
  assign half_m1     = CNT_W'(mdc_ratio(cr_q) / 2 - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      wr_q  <= 1'b0;
      cr_q  <= '0;
      reg_q <= '0;
      phy_q <= '0;
    end else if (cmd_wr && !busy) begin
      busy  <= cmd_wdata[BUSY_BIT];
      wr_q  <= cmd_wdata[WR_BIT];
      cr_q  <= cmd_wdata[CR_LSB +: 3];
      reg_q <= cmd_wdata[REG_LSB +: 5];
      phy_q <= cmd_wdata[PHY_LSB +: 5];
    end else if (done_evt) begin
      busy  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  data_q <= '0;
    else if (data_wr && !busy)   data_q <= data_wdata;
    else if (done_evt && !wr_q)  data_q <= rx_word;
  end

  mdio_mdc_gen #(.CNT_W(CNT_W)) mdc_gen_i (
    .clk(clk), .rst_n(rst_n), .run(busy), .half_m1(half_m1),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_frame_shifter #(.PRE_LEN(PRE_LEN)) shifter_i (
    .clk(clk), .rst_n(rst_n), .start(start_evt),
    .rise_evt(rise_evt), .fall_evt(fall_evt),
    .wr(wr_q), .phy(phy_q), .regad(reg_q), .wdata(data_q),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(done_evt), .rdata(rx_word), .bit_idx(bit_idx)
  );

  assign cmd_rdata  = {16'b0, phy_q, reg_q, 1'b0, cr_q, wr_q, busy};
  assign data_rdata = data_q;
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
`timescale 1ns/1ps
module mdio_mgmt_master_chk #(
  parameter int PRE_LEN = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] cmd_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        done_evt,
  input logic        wr_sel,
  input logic [$clog2(PRE_LEN+32)-1:0] bit_idx
);
  localparam int IDX_W = $clog2(PRE_LEN + 32);
  localparam logic [IDX_W-1:0] TA_FIRST = IDX_W'(PRE_LEN + 14);

  logic busy;
  assign busy = cmd_rdata[0];

  a_r3_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  a_r3_busy_clears_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $fell(mdc));

  a_r3_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> busy);

  a_r7_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_rdata[15:1]));

  a_r5_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_sel && (bit_idx >= TA_FIRST)) |-> !mdio_oe);

  a_r9_data_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$stable(mdio_o)) |-> $fell(mdc));

  a_r9_enable_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$stable(mdio_oe)) |-> $fell(mdc));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk #(.PRE_LEN(PRE_LEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_rdata(cmd_rdata), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done_evt(done_evt),
  .wr_sel(wr_q), .bit_idx(bit_idx)
);

// File: tb/mdio_mgmt_master_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        data_wr = 1'b0;
  logic [15:0] data_wdata = '0;
  logic [31:0] cmd_rdata;
  logic [15:0] data_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  localparam logic [4:0] PHY_HERE = 5'd3;

  int checks = 0;
  int errors = 0;
  int rcnt = 0;
  int r9_viol = 0;
  logic [63:0] cap_val = '0;
  logic [63:0] cap_oe = '0;
  bit finished = 0;

  always #2 clk = ~clk;

  mdio_mgmt_master dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .data_wr(data_wr), .data_wdata(data_wdata), .cmd_rdata(cmd_rdata),
    .data_rdata(data_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  function automatic int ratio_of(input logic [2:0] c);
    if (c == 3'd2) return 16;
    if (c == 3'd3) return 26;
    if (c == 3'd0) return 42;
    return 62;
  endfunction

  function automatic logic [15:0] phy_answer(input logic [4:0] r);
    return 16'h9C35 ^ {r, 6'b0, r};
  endfunction

  function automatic logic [31:0] cmd_word(input logic [4:0] phy, input logic [4:0] r,
                                           input logic [2:0] cr, input logic wr, input logic go);
    return {16'b0, phy, r, 1'b0, cr, wr, go};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // PHY model: record on MDC rise, answer on MDC fall
  always @(posedge mdc) begin
    if (rcnt < 64) begin
      cap_val[63 - rcnt] = mdio_o;
      cap_oe[63 - rcnt]  = mdio_oe;
    end
    rcnt++;
  end

  always @(negedge mdc) begin
    logic is_rd;
    is_rd = cap_val[29];
    if (rcnt == 47 && is_rd && cap_val[27:23] == PHY_HERE)
      mdio_i = 1'b0;
    else if (rcnt >= 48 && rcnt <= 63 && is_rd && cap_val[27:23] == PHY_HERE)
      mdio_i = phy_answer(cap_val[22:18])[63 - rcnt];
    else
      mdio_i = 1'b1;
  end

  // R9 monitor: output moves only with a falling MDC or at start
  logic prev_o = 1'b1, prev_oe = 1'b0, prev_mdc = 1'b0, prev_busy = 1'b0;
  always @(negedge clk) begin
    if (rst_n && ((mdio_o !== prev_o) || (mdio_oe !== prev_oe)) &&
        !(prev_mdc && !mdc) && !(!prev_busy && cmd_rdata[0]))
      r9_viol++;
    prev_o = mdio_o; prev_oe = mdio_oe; prev_mdc = mdc; prev_busy = cmd_rdata[0];
  end

  task automatic run_txn(input logic wr, input logic [2:0] cr, input logic [4:0] phy,
                         input logic [4:0] r, input logic [15:0] wd,
                         input bit meddle, input bit collide,
                         output int cycles, output int highs);
    int exp_cyc;
    exp_cyc = 64 * ratio_of(cr);
    @(negedge clk);
    data_wr = 1'b1; data_wdata = wd;
    @(negedge clk);
    data_wr = 1'b0;
    cmd_wr = 1'b1; cmd_wdata = cmd_word(phy, r, cr, wr, 1'b1);
    rcnt = 0;
    @(negedge clk);
    cmd_wr = 1'b0;
    cycles = 0; highs = 0;
    forever begin
      if (meddle && cycles == 200) begin
        cmd_wr = 1'b1; cmd_wdata = cmd_word(5'd30, 5'd29, 3'd1, ~wr, 1'b1);
        data_wr = 1'b1; data_wdata = ~wd;
      end else if (collide && cycles == exp_cyc - 1) begin
        cmd_wr = 1'b1; cmd_wdata = cmd_word(5'd31, 5'd31, 3'd2, 1'b1, 1'b1);
      end else begin
        cmd_wr = 1'b0; data_wr = 1'b0;
      end
      @(posedge clk);
      cycles++;
      @(negedge clk);
      if (mdc) highs++;
      if (!cmd_rdata[0] || cycles > 20000) break;
    end
    cmd_wr = 1'b0; data_wr = 1'b0;
  endtask

  task automatic do_write(input logic [2:0] cr, input logic [4:0] phy, input logic [4:0] r,
                          input logic [15:0] wd, input bit meddle);
    int cyc, hi;
    run_txn(1'b1, cr, phy, r, wd, meddle, 1'b0, cyc, hi);
    check(cyc == 64 * ratio_of(cr), "R2", "write length", cyc, 64 * ratio_of(cr));
    check(hi == 32 * ratio_of(cr), "R2", "MDC high time", hi, 32 * ratio_of(cr));
    check(cap_val == {32'hFFFF_FFFF, 2'b01, 2'b01, phy, r, 2'b10, wd}, meddle ? "R7" : "R4",
          "write frame", cap_val, {32'hFFFF_FFFF, 2'b01, 2'b01, phy, r, 2'b10, wd});
    check(cap_oe == 64'hFFFF_FFFF_FFFF_FFFF, "R4", "write enable", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
    check(cmd_rdata == cmd_word(phy, r, cr, 1'b1, 1'b0), meddle ? "R7" : "R3",
          "fields after write", cmd_rdata, cmd_word(phy, r, cr, 1'b1, 1'b0));
    check(data_rdata == wd, meddle ? "R7" : "R4", "data word kept", data_rdata, wd);
  endtask

  task automatic do_read(input logic [2:0] cr, input logic [4:0] phy, input logic [4:0] r,
                         input bit collide);
    int cyc, hi;
    logic [15:0] exp_d;
    exp_d = (phy == PHY_HERE) ? phy_answer(r) : 16'hFFFF;
    run_txn(1'b0, cr, phy, r, 16'h0000, 1'b0, collide, cyc, hi);
    check(cyc == 64 * ratio_of(cr), "R2", "read length", cyc, 64 * ratio_of(cr));
    check(cap_val[63:18] == {32'hFFFF_FFFF, 2'b01, 2'b10, phy, r}, "R5", "read header",
          cap_val[63:18], {32'hFFFF_FFFF, 2'b01, 2'b10, phy, r});
    check(cap_oe == {{46{1'b1}}, 18'b0}, "R5", "read enable", cap_oe, {{46{1'b1}}, 18'b0});
    check(data_rdata == exp_d, (phy == PHY_HERE) ? "R5" : "R6", "read data", data_rdata, exp_d);
    check(cmd_rdata == cmd_word(phy, r, cr, 1'b0, 1'b0), collide ? "R7" : "R3",
          "fields after read", cmd_rdata, cmd_word(phy, r, cr, 1'b0, 1'b0));
    if (collide) begin
      repeat (40) @(negedge clk);
      check(!cmd_rdata[0] && !mdc, "R7", "no restart after collision",
            {cmd_rdata[0], mdc}, 2'b00);
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cmd_rdata == 32'h0, "R1", "command after reset", cmd_rdata, 0);
    check(data_rdata == 16'h0, "R1", "data after reset", data_rdata, 0);
    check({mdc, mdio_oe, mdio_o} == 3'b001, "R1", "pins after reset", {mdc, mdio_oe, mdio_o}, 3'b001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2/R4: every clock-range code, including reserved ones
    for (int c = 0; c < 8; c++)
      do_write(3'(c), 5'(c + 1), 5'(3 * c), 16'hC3A5 ^ (16'h1 << c), 1'b0);

    // R5 reads from the present PHY at several registers
    do_read(3'd2, PHY_HERE, 5'd1, 1'b0);
    do_read(3'd3, PHY_HERE, 5'd31, 1'b0);
    do_read(3'd2, PHY_HERE, 5'd16, 1'b0);
    // R6 absent PHY
    do_read(3'd2, 5'd9, 5'd2, 1'b0);
    // R7 writes while busy, mid-frame and on the completion edge
    do_write(3'd2, 5'd17, 5'd4, 16'h5AA5, 1'b1);
    do_read(3'd3, PHY_HERE, 5'd7, 1'b1);

    // R8 command write without start
    @(negedge clk);
    cmd_wr = 1'b1; cmd_wdata = 32'hFFFF_0020 | cmd_word(5'd21, 5'd10, 3'd5, 1'b1, 1'b0);
    @(negedge clk);
    cmd_wr = 1'b0;
    repeat (40) @(negedge clk);
    check(cmd_rdata == cmd_word(5'd21, 5'd10, 3'd5, 1'b1, 1'b0), "R8", "fields without start",
          cmd_rdata, cmd_word(5'd21, 5'd10, 3'd5, 1'b1, 1'b0));
    check(!mdc && !mdio_oe, "R8", "bus idle without start", {mdc, mdio_oe}, 2'b00);

    check(r9_viol == 0, "R9", "MDIO moves off falling MDC", r9_viol, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule